// File: doc/BRIEF.md
# Per-Bank Precharge Timing Guard

This block follows the command stream of a four-bank DRAM and tells the controller, bank by bank, whether a precharge may be issued now. Reads and writes (plain or with auto-precharge) open a window during which a precharge to the same bank is premature. The window length comes from the configured additive latency, write latency, burst length, read-to-precharge delay and write recovery. A precharge to a bank also starts that bank's precharge period, and the bank is reported idle once the configured row-precharge time has passed.

Each bank owns a pair of saturating down-counters. The first holds the clocks left before a precharge becomes legal. When a command arrives while the counter is still running, the counter is reloaded with the later of the two deadlines. The second holds the clocks left in the precharge period, and every precharge restarts it, whether the precharge targets one bank or all of them. If a precharge arrives too early, the block raises a one-clock violation flag and still records the command, so later tracking stays consistent. The configuration inputs are read when a command is accepted, and the controller holds them steady while traffic flows.

Top module: `prechg_guard`

## Requirements
- R1: After reset every bit of `pre_ok` and `bank_idle` is 1, `pre_all_ok` is 1 and `early_pre` is 0.
- R2: After a read (`cmd_kind` 1) or read with auto-precharge (`cmd_kind` 2) to bank b, sampled at edge n, `pre_ok[b]` is 0 until a precharge sampled at edge n+D would be legal, where D = AL + BL/2 + max(RTP,2) - 2, and BL is 8 when `cfg_bl8`=1 and 4 when it is 0.
- R3: After a write (`cmd_kind` 3) or write with auto-precharge (`cmd_kind` 4) to bank b, the same rule holds with D = WL + BL/2 + WR.
- R4: A read or write that reaches a bank whose count is still running leaves that bank blocked until the later of the old and the new deadline.
- R5: A precharge (`cmd_kind` 5) places only a one-clock constraint on a following precharge to the same bank, so a precharge on the next cycle raises no violation.
- R6: `pre_all_ok` is 1 only when every bit of `pre_ok` is 1. A precharge with `all_banks`=1 applies to every bank.
- R7: A precharge sampled while its target bank is blocked sets `early_pre` for exactly the following cycle. For a precharge-all, the target is any bank. The precharge is still recorded.
- R8: After a precharge sampled at edge n that reaches bank b, `bank_idle[b]` is 0 until edge n + max(tRP,1). The period restarts at each later precharge to that bank, single or all.
- R9: A read or write to bank b drives `bank_idle[b]` to 0 on the next cycle, and it stays 0 until a precharge reaches that bank.
- R10: While `cmd_valid` is 0 the other command inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_kind | input | 3 | 1 read, 2 read+AP, 3 write, 4 write+AP, 5 precharge |
| cmd_bank | input | BW (2) | Target bank |
| all_banks | input | 1 | With a precharge: apply to every bank |
| cfg_al | input | CW (4) | Additive latency, clocks |
| cfg_wl | input | CW (4) | Write latency, clocks |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects burst length 4 |
| cfg_rtp | input | CW (4) | Read-to-precharge delay, clocks (rounded up) |
| cfg_wr | input | CW (4) | Write recovery, clocks |
| cfg_trp | input | CW (4) | Row precharge time, clocks |
| pre_ok | output | NB (4) | Per bank: a precharge sampled at the next edge is legal |
| pre_all_ok | output | 1 | A precharge-all sampled at the next edge is legal |
| bank_idle | output | NB (4) | Per bank: closed, with its precharge period complete |
| early_pre | output | 1 | One-cycle flag for a premature precharge |

## Verification
Two functions can fall on the same edge. In the first, the countdown of an earlier deadline meets the reload from a new read or write, so the later deadline must win. The bench provokes this with back-to-back write-then-read and read-then-write pairs that have deliberately unequal delays, and it requires the release cycle to equal the arithmetic maximum. In the second, a premature precharge both raises the violation flag and restarts the precharge period. The bench checks the flag in the next cycle and then times the idle rise from that same command.

// File: rtl/prechg_guard_pkg.sv
package prechg_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_RD    = 3'd1,
        CMD_RD_AP = 3'd2,
        CMD_WR    = 3'd3,
        CMD_WR_AP = 3'd4,
        CMD_PRE   = 3'd5
    } cmd_kind_e;

    function automatic logic is_read(input logic [2:0] k);
        return (k == CMD_RD) || (k == CMD_RD_AP);
    endfunction

    function automatic logic is_write(input logic [2:0] k);
        return (k == CMD_WR) || (k == CMD_WR_AP);
    endfunction

endpackage

// File: rtl/prechg_delay_calc.sv
module prechg_delay_calc #(
    parameter int CW = 4,
    parameter int DW = CW + 2
) (
    input  logic [CW-1:0] cfg_al,
    input  logic [CW-1:0] cfg_wl,
    input  logic          cfg_bl8,
    input  logic [CW-1:0] cfg_rtp,
    input  logic [CW-1:0] cfg_wr,
    input  logic [CW-1:0] cfg_trp,
    output logic [DW-1:0] rd_load,
    output logic [DW-1:0] wr_load,
    output logic [DW-1:0] rp_load
);
    logic [DW-1:0] half_burst;
    logic [DW-1:0] rtp_eff;
    logic [DW-1:0] rd_gap;
    logic [DW-1:0] wr_gap;

    always_comb begin
        half_burst = cfg_bl8 ? DW'(4) : DW'(2);
        rtp_eff    = (cfg_rtp < CW'(2)) ? DW'(2) : DW'(cfg_rtp);
        // read gap is at least 2, write gap is at least 2
        rd_gap     = DW'(cfg_al) + half_burst + rtp_eff - DW'(2);
        wr_gap     = DW'(cfg_wl) + half_burst + DW'(cfg_wr);
        // counters hold the clocks still to wait after the accepting edge
        rd_load    = rd_gap - DW'(1);
        wr_load    = wr_gap - DW'(1);
        rp_load    = (cfg_trp == '0) ? '0 : DW'(cfg_trp) - DW'(1);
    end
endmodule

// File: rtl/prechg_bank_slot.sv
module prechg_bank_slot
    import prechg_guard_pkg::*;
#(
    parameter int DW  = 6,
    parameter int BW  = 2,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_kind,
    input  logic [BW-1:0] cmd_bank,
    input  logic          all_banks,
    input  logic [DW-1:0] rd_load,
    input  logic [DW-1:0] wr_load,
    input  logic [DW-1:0] rp_load,
    output logic          pre_ok,
    output logic          idle
);
    typedef struct packed {
        logic          open;
        logic [DW-1:0] gap;
        logic [DW-1:0] rp;
    } slot_t;

    slot_t s_d, s_q;
    logic          hit;
    logic          is_pre;
    logic [DW-1:0] gap_dec;
    logic [DW-1:0] rp_dec;

    always_comb begin
        is_pre  = (cmd_kind == CMD_PRE);
        hit     = cmd_valid && ((cmd_bank == BW'(IDX)) || (is_pre && all_banks));
        gap_dec = (s_q.gap == '0) ? '0 : s_q.gap - DW'(1);
        rp_dec  = (s_q.rp == '0) ? '0 : s_q.rp - DW'(1);
        s_d     = s_q;
        s_d.gap = gap_dec;
        s_d.rp  = rp_dec;
        if (hit) begin
            if (is_read(cmd_kind)) begin
                s_d.gap  = (rd_load > gap_dec) ? rd_load : gap_dec;
                s_d.open = 1'b1;
            end else if (is_write(cmd_kind)) begin
                s_d.gap  = (wr_load > gap_dec) ? wr_load : gap_dec;
                s_d.open = 1'b1;
            end else if (is_pre) begin
                // one-clock precharge-to-precharge spacing adds no wait
                s_d.open = 1'b0;
                s_d.rp   = rp_load;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pre_ok = (s_q.gap == '0);
    assign idle   = !s_q.open && (s_q.rp == '0);
endmodule

// File: rtl/prechg_guard.sv
module prechg_guard
    import prechg_guard_pkg::*;
#(
    parameter int NB = 4,
    parameter int CW = 4,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1,
    localparam int DW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_kind,
    input  logic [BW-1:0] cmd_bank,
    input  logic          all_banks,
    input  logic [CW-1:0] cfg_al,
    input  logic [CW-1:0] cfg_wl,
    input  logic          cfg_bl8,
    input  logic [CW-1:0] cfg_rtp,
    input  logic [CW-1:0] cfg_wr,
    input  logic [CW-1:0] cfg_trp,
    output logic [NB-1:0] pre_ok,
    output logic          pre_all_ok,
    output logic [NB-1:0] bank_idle,
    output logic          early_pre
);
    typedef struct packed {
        logic early;
    } top_t;

    top_t t_d, t_q;
    logic [DW-1:0] rd_load;
    logic [DW-1:0] wr_load;
    logic [DW-1:0] rp_load;

    prechg_delay_calc #(.CW(CW), .DW(DW)) u_calc (
        .cfg_al  (cfg_al),
        .cfg_wl  (cfg_wl),
        .cfg_bl8 (cfg_bl8),
        .cfg_rtp (cfg_rtp),
        .cfg_wr  (cfg_wr),
        .cfg_trp (cfg_trp),
        .rd_load (rd_load),
        .wr_load (wr_load),
        .rp_load (rp_load)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        prechg_bank_slot #(.DW(DW), .BW(BW), .IDX(i)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_valid (cmd_valid),
            .cmd_kind  (cmd_kind),
            .cmd_bank  (cmd_bank),
            .all_banks (all_banks),
            .rd_load   (rd_load),
            .wr_load   (wr_load),
            .rp_load   (rp_load),
            .pre_ok    (pre_ok[i]),
            .idle      (bank_idle[i])
        );
    end

    assign pre_all_ok = &pre_ok;

    always_comb begin
        t_d.early = 1'b0;
        if (cmd_valid && (cmd_kind == CMD_PRE)) begin
            t_d.early = all_banks ? !pre_all_ok : !pre_ok[cmd_bank];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign early_pre = t_q.early;
endmodule

// File: rtl/prechg_guard_chk.sv
module prechg_guard_chk #(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_kind,
    input logic [BW-1:0] cmd_bank,
    input logic          all_banks,
    input logic [NB-1:0] pre_ok,
    input logic [NB-1:0] bank_idle,
    input logic          early_pre
);
    logic rdwr;
    logic pre_cmd;
    assign rdwr    = cmd_valid && (cmd_kind >= 3'd1) && (cmd_kind <= 3'd4);
    assign pre_cmd = cmd_valid && (cmd_kind == 3'd5);

    // R7: the flag only follows a precharge
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        early_pre |-> $past(pre_cmd));

    // R7: a blocked single-bank precharge raises the flag
    a_r7_flag_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cmd && !all_banks && !pre_ok[cmd_bank]) |=> early_pre);

    // R7: the flag lasts one cycle when no further precharge comes
    a_r7_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (early_pre && !pre_cmd) |=> !early_pre);

    // R2, R3: every read or write blocks its bank on the next cycle
    a_r2_r3_block: assert property (@(posedge clk) disable iff (!rst_n)
        rdwr |=> !pre_ok[$past(cmd_bank)]);

    // R9: the bank leaves idle after a read or write
    a_r9_open: assert property (@(posedge clk) disable iff (!rst_n)
        rdwr |=> !bank_idle[$past(cmd_bank)]);

    for (genvar i = 0; i < NB; i++) begin : g_bank
        // R4: once allowed, a bank stays allowed until a read or write reaches it
        a_r4_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_ok[i] && !(rdwr && (cmd_bank == BW'(i)))) |=> pre_ok[i]);
        // R9: an idle bank stays idle unless a command reaches it
        a_r9_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_idle[i] && !(cmd_valid && (cmd_bank == BW'(i)))
                && !(pre_cmd && all_banks)) |=> bank_idle[i]);
    end
endmodule

bind prechg_guard prechg_guard_chk #(.NB(NB), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_bank  (cmd_bank),
    .all_banks (all_banks),
    .pre_ok    (pre_ok),
    .bank_idle (bank_idle),
    .early_pre (early_pre)
);

// File: tb/prechg_guard_test.sv
module prechg_guard_test;
    localparam int NB = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [2:0]    cmd_kind;
    logic [1:0]    cmd_bank;
    logic          all_banks;
    logic [CW-1:0] cfg_al, cfg_wl, cfg_rtp, cfg_wr, cfg_trp;
    logic          cfg_bl8;
    logic [NB-1:0] pre_ok;
    logic          pre_all_ok;
    logic [NB-1:0] bank_idle;
    logic          early_pre;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    prechg_guard #(.NB(NB), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .all_banks(all_banks), .cfg_al(cfg_al), .cfg_wl(cfg_wl),
        .cfg_bl8(cfg_bl8), .cfg_rtp(cfg_rtp), .cfg_wr(cfg_wr), .cfg_trp(cfg_trp),
        .pre_ok(pre_ok), .pre_all_ok(pre_all_ok), .bank_idle(bank_idle),
        .early_pre(early_pre)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at a falling edge, sampled at the next rising edge; returns one falling edge later
    task automatic cmd(input int kind, input int bank, input bit all);
        cmd_valid = 1'b1;
        cmd_kind  = 3'(kind);
        cmd_bank  = 2'(bank);
        all_banks = all;
        @(negedge clk);
        cmd_valid = 1'b0;
        all_banks = 1'b0;
    endtask

    task automatic wait_ok(input int b, output int k);
        k = 1;
        while (!pre_ok[b] && k < 100) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic wait_idle(input int b, output int k);
        k = 1;
        while (!bank_idle[b] && k < 100) begin
            @(negedge clk);
            k++;
        end
    endtask

    function automatic int rd_exp(input int al, input bit bl8, input int rtp);
        return al + (bl8 ? 4 : 2) + ((rtp < 2) ? 2 : rtp) - 2;
    endfunction

    function automatic int wr_exp(input int wl, input bit bl8, input int wr);
        return wl + (bl8 ? 4 : 2) + wr;
    endfunction

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        int n;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 3'd0; cmd_bank = 2'd0; all_banks = 1'b0;
        cfg_al = 4'd0; cfg_wl = 4'd2; cfg_bl8 = 1'b0; cfg_rtp = 4'd2; cfg_wr = 4'd3; cfg_trp = 4'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pre_ok", int'(pre_ok), 15);
        check("R1 bank_idle", int'(bank_idle), 15);
        check("R1 pre_all_ok", int'(pre_all_ok), 1);
        check("R1 early_pre", int'(early_pre), 0);

        // R10: command fields without valid do nothing
        cmd_valid = 1'b0; cmd_kind = 3'd1; cmd_bank = 2'd2;
        @(negedge clk);
        @(negedge clk);
        check("R10 pre_ok", int'(pre_ok), 15);
        check("R10 bank_idle", int'(bank_idle), 15);

        // R2 sweep over read configuration
        n = 0;
        for (int al = 0; al < 4; al++) begin
            for (int rtp = 0; rtp < 6; rtp++) begin
                for (int bl = 0; bl < 2; bl++) begin
                    cfg_al = 4'(al); cfg_rtp = 4'(rtp); cfg_bl8 = bl[0];
                    cmd((n % 2 == 0) ? 1 : 2, n % 4, 1'b0);
                    check("R9 idle after read", int'(bank_idle[n % 4]), 0);
                    wait_ok(n % 4, k);
                    check("R2 read delay", k, rd_exp(al, bl[0], rtp));
                    cmd(5, n % 4, 1'b0);
                    n++;
                    settle();
                end
            end
        end

        // R3 sweep over write configuration
        for (int wl = 1; wl < 5; wl++) begin
            for (int wr = 1; wr < 6; wr++) begin
                for (int bl = 0; bl < 2; bl++) begin
                    cfg_wl = 4'(wl); cfg_wr = 4'(wr); cfg_bl8 = bl[0];
                    cmd((n % 2 == 0) ? 3 : 4, n % 4, 1'b0);
                    wait_ok(n % 4, k);
                    check("R3 write delay", k, wr_exp(wl, bl[0], wr));
                    cmd(5, n % 4, 1'b0);
                    n++;
                    settle();
                end
            end
        end

        // R4: write then read, longer write deadline wins
        cfg_al = 4'd0; cfg_rtp = 4'd2; cfg_bl8 = 1'b0; cfg_wl = 4'd4; cfg_wr = 4'd5;
        cmd(3, 1, 1'b0);
        cmd(1, 1, 1'b0);
        wait_ok(1, k);
        check("R4 write then read", k, 10);
        cmd(5, 1, 1'b0);
        settle();
        // R4: read then write, longer read deadline wins
        cfg_al = 4'd9; cfg_rtp = 4'd4; cfg_bl8 = 1'b1; cfg_wl = 4'd1; cfg_wr = 4'd1;
        cmd(2, 2, 1'b0);
        cmd(4, 2, 1'b0);
        wait_ok(2, k);
        check("R4 read then write", k, 14);
        cmd(5, 2, 1'b0);
        settle();

        // R5: precharge followed at once by precharge
        cmd(5, 0, 1'b0);
        cmd(5, 0, 1'b0);
        check("R5 no flag", int'(early_pre), 0);
        check("R5 pre_ok kept", int'(pre_ok[0]), 1);
        settle();

        // R7: premature single precharge, still recorded
        cfg_al = 4'd0; cfg_rtp = 4'd2; cfg_bl8 = 1'b0; cfg_trp = 4'd4;
        cmd(1, 1, 1'b0);
        cmd(5, 1, 1'b0);
        check("R7 flag raised", int'(early_pre), 1);
        wait_idle(1, k);
        check("R7 recorded idle timing", k, 4);
        check("R7 flag single cycle", int'(early_pre), 0);
        settle();

        // R6: precharge-all gating and broadcast
        cmd(1, 2, 1'b0);
        check("R6 pre_all_ok low", int'(pre_all_ok), 0);
        check("R6 other bank ok", int'(pre_ok[0]), 1);
        cmd(5, 0, 1'b1);
        check("R7 all-bank flag", int'(early_pre), 1);
        check("R6 all banks restarted", int'(bank_idle), 0);
        wait_idle(0, k);
        check("R6 broadcast idle timing", k, 4);
        check("R6 bank2 closed", int'(bank_idle[2]), 1);
        settle();
        check("R6 pre_all_ok high", int'(pre_all_ok), 1);

        // R8: latest precharge restarts the period
        cfg_trp = 4'd5;
        cmd(5, 3, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R8 still busy", int'(bank_idle[3]), 0);
        cmd(5, 0, 1'b1);
        wait_idle(3, k);
        check("R8 restart by all", k, 5);
        settle();
        cfg_trp = 4'd0;
        cmd(5, 2, 1'b0);
        check("R8 zero tRP", int'(bank_idle[2]), 1);
        cfg_trp = 4'd1;
        cmd(5, 2, 1'b0);
        check("R8 one tRP", int'(bank_idle[2]), 1);
        cfg_trp = 4'd2;
        cmd(5, 2, 1'b0);
        check("R8 two tRP", int'(bank_idle[2]), 0);
        settle();

        // R9: open bank stays non-idle until precharged
        cmd(3, 0, 1'b0);
        repeat (30) @(negedge clk);
        check("R9 stays open", int'(bank_idle[0]), 0);
        cmd(5, 0, 1'b0);
        settle();
        check("R9 closed", int'(bank_idle[0]), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule